// File: doc/BRIEF.md
# Byte Accumulator Instruction Sequencer

This block is the control core of a small byte-wide accumulator machine. It holds the program counter, the instruction register, an operand register and the accumulator. A multi-cycle state machine fetches one-byte opcodes, and a second operand byte where the opcode needs one, from an external program memory with a combinational read port. It then carries out the instruction through strobes to an external data memory, an input FIFO and an output FIFO.

Six instructions are decoded, all by the high nibble of the opcode:

| Opcode | Action |
|---|---|
| 0x0_ | Input pop |
| 0x1_ | Output push |
| 0x2_ | Load from memory |
| 0x3_ | Store to memory |
| 0x8_ | Jump |
| 0x9_ | Jump if the accumulator is zero |

The two load and store forms use opcode bits [1:0] as a short operand field. The values 0 to 2 name a data address directly, so the instruction is one byte long. The value 3 means that an address byte follows. While the input FIFO is empty or the output FIFO is full, the machine waits in its decode step and does not move. Any other high nibble stops the machine for good.

Top module: `byte_seq_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0 and the machine returns to fetch. After reset, the first byte is read from program address 0, and no strobe or `halted` is high.
- R2: Opcode 0x00 pulses `in_pop` for one cycle with the accumulator loading `in_data`. The instruction is one byte long, and `in_pop` is never high while `in_empty` is high.
- R3: While an input-pop opcode meets an empty input FIFO, the machine stays in decode each cycle with `prog_addr` unchanged, and it resumes in the cycle after data shows up.
- R4: Opcode 0x10 pulses `out_push` with `out_data` equal to the accumulator, and the instruction is one byte long. While `out_full` is high, `out_push` stays low and the machine waits.
- R5: Opcode 0x80 followed by a target byte always moves the PC to the target.
- R6: Opcode 0x90 followed by a target byte moves the PC to the target only when the accumulator is 0. Otherwise execution continues at the byte after the target byte.
- R7: Opcode 0x23 followed by an address byte loads the accumulator from `mem_rdata`, with `mem_addr` equal to the address byte and `mem_addr_sel` low.
- R8: Opcode 0x33 followed by an address byte pulses `mem_we` for one cycle, with `mem_wdata` equal to the accumulator and `mem_addr` equal to the address byte.
- R9: Opcodes 0x20 to 0x22 and 0x30 to 0x32 are one byte long. They use address opcode[1:0], assert `mem_addr_sel`, and fetch no operand byte.
- R10: An opcode whose high nibble is not 0, 1, 2, 3, 8 or 9 raises `halted` for good. Once halted, the PC no longer moves and no strobe is raised.
- R11: At most one of `in_pop`, `out_push` and `mem_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | PA_W | Program memory address (the PC) |
| prog_data | input | 8 | Program byte at prog_addr, read combinationally |
| mem_addr | output | DA_W | Data memory address |
| mem_wdata | output | 8 | Data memory write value (the accumulator) |
| mem_we | output | 1 | Data memory write strobe |
| mem_rdata | input | 8 | Data memory read value at mem_addr |
| mem_addr_sel | output | 1 | 0: address from the operand byte; 1: address from the short opcode field |
| in_empty | input | 1 | Input FIFO has no data |
| in_data | input | 8 | Head of the input FIFO |
| in_pop | output | 1 | Input FIFO pop strobe |
| out_full | input | 1 | Output FIFO cannot accept data |
| out_data | output | 8 | Value pushed to the output FIFO (the accumulator) |
| out_push | output | 1 | Output FIFO push strobe |
| halted | output | 1 | Machine stopped on an unknown opcode |

## Verification
The assertions check on every cycle the properties that hold locally. FIFO strobes never go against their flow-control flags, and the strobes are mutually exclusive. An empty input FIFO freezes the PC while the machine sits in decode. A taken jump lands on the operand byte, short-form writes stay inside addresses 0 to 2, and the halt state is sticky. Other behaviour only shows up over the course of a program: the instruction lengths, JUMPZ falling through when the accumulator is non-zero, the value loaded by a short-form read, and the ordering of the output stream. These are shown by the bench's behavioural model and its end-of-program memory and output contents.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_OPND, S_EXEC, S_HALT
  } state_t;

  typedef enum logic [2:0] {
    K_IN, K_OUT, K_LOAD, K_STORE, K_JMP, K_JZ, K_BAD
  } kind_t;

  localparam logic [1:0] LONG_FORM = 2'b11;

  // Instruction kind from the high nibble of the opcode.
  function automatic kind_t classify(input logic [7:0] op);
    case (op[7:4])
      4'h0:    return K_IN;
      4'h1:    return K_OUT;
      4'h2:    return K_LOAD;
      4'h3:    return K_STORE;
      4'h8:    return K_JMP;
      4'h9:    return K_JZ;
      default: return K_BAD;
    endcase
  endfunction

  // Memory instruction whose address sits in the opcode itself.
  function automatic logic short_form(input logic [7:0] op);
    return (op[7:4] == 4'h2 || op[7:4] == 4'h3) && (op[1:0] != LONG_FORM);
  endfunction

  function automatic logic branch_taken(input kind_t k, input logic [7:0] a);
    return (k == K_JMP) || (k == K_JZ && a == 8'h00);
  endfunction

endpackage

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int PA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            load,
  input  logic [PA_W-1:0] target,
  output logic [PA_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (load) pc <= target;
    else if (inc)  pc <= pc + PA_W'(1);
  end
endmodule

// File: rtl/seq_decode.sv
module seq_decode (
  input  logic [7:0]    ir,
  input  logic [7:0]    acc,
  output seq_pkg::kind_t kind,
  output logic          is_short,
  output logic          take
);
  import seq_pkg::*;
  always_comb begin
    kind     = classify(ir);
    is_short = short_form(ir);
    take     = branch_taken(kind, acc);
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm (
  input  logic           clk,
  input  logic           rst,
  input  seq_pkg::kind_t kind,
  input  logic           is_short,
  input  logic           take,
  input  logic           in_empty,
  input  logic           out_full,
  output seq_pkg::state_t state,
  output logic           ir_load,
  output logic           opnd_load,
  output logic           pc_inc,
  output logic           pc_load,
  output logic           pop,
  output logic           push,
  output logic           wr,
  output logic           acc_from_mem
);
  import seq_pkg::*;
  state_t nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    nxt          = state;
    ir_load      = 1'b0;
    opnd_load    = 1'b0;
    pc_inc       = 1'b0;
    pc_load      = 1'b0;
    pop          = 1'b0;
    push         = 1'b0;
    wr           = 1'b0;
    acc_from_mem = 1'b0;
    case (state)
      S_FETCH: begin
        ir_load = 1'b1;
        pc_inc  = 1'b1;
        nxt     = S_DECODE;
      end
      S_DECODE: begin
        case (kind)
          K_IN: if (!in_empty) begin
            pop = 1'b1;
            nxt = S_FETCH;
          end
          K_OUT: if (!out_full) begin
            push = 1'b1;
            nxt  = S_FETCH;
          end
          K_LOAD, K_STORE: nxt = is_short ? S_EXEC : S_OPND;
          K_JMP, K_JZ:     nxt = S_OPND;
          default:         nxt = S_HALT;
        endcase
      end
      S_OPND: begin
        opnd_load = 1'b1;
        pc_inc    = 1'b1;
        nxt       = S_EXEC;
      end
      S_EXEC: begin
        acc_from_mem = (kind == K_LOAD);
        wr           = (kind == K_STORE);
        pc_load      = take;
        nxt          = S_FETCH;
      end
      default: nxt = S_HALT;
    endcase
  end
endmodule

// File: rtl/byte_seq_core.sv
module byte_seq_core #(
  parameter int PA_W = 8,
  parameter int DA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PA_W-1:0] prog_addr,
  input  logic [7:0]      prog_data,
  output logic [DA_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            mem_we,
  input  logic [7:0]      mem_rdata,
  output logic            mem_addr_sel,
  input  logic            in_empty,
  input  logic [7:0]      in_data,
  output logic            in_pop,
  input  logic            out_full,
  output logic [7:0]      out_data,
  output logic            out_push,
  output logic            halted
);
  import seq_pkg::*;

  logic [7:0] ir, opnd, acc;
  kind_t      kind;
  state_t     state;
  logic       is_short, take;
  logic       ir_load, opnd_load, pc_inc, pc_load, acc_from_mem;

  seq_decode u_dec (
    .ir(ir), .acc(acc), .kind(kind), .is_short(is_short), .take(take)
  );

  seq_fsm u_fsm (
    .clk(clk), .rst(rst), .kind(kind), .is_short(is_short), .take(take),
    .in_empty(in_empty), .out_full(out_full), .state(state),
    .ir_load(ir_load), .opnd_load(opnd_load), .pc_inc(pc_inc),
    .pc_load(pc_load), .pop(in_pop), .push(out_push), .wr(mem_we),
    .acc_from_mem(acc_from_mem)
  );

  seq_pc #(.PA_W(PA_W)) u_pc (
    .clk(clk), .rst(rst), .inc(pc_inc), .load(pc_load),
    .target(opnd[PA_W-1:0]), .pc(prog_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir   <= '0;
      opnd <= '0;
      acc  <= '0;
    end else begin
      if (ir_load)      ir   <= prog_data;
      if (opnd_load)    opnd <= prog_data;
      if (in_pop)       acc  <= in_data;
      if (acc_from_mem) acc  <= mem_rdata;
    end
  end

  assign mem_addr_sel = is_short;
  assign mem_addr     = is_short ? DA_W'(ir[1:0]) : opnd[DA_W-1:0];
  assign mem_wdata    = acc;
  assign out_data     = acc;
  assign halted       = (state == S_HALT);
endmodule

// File: rtl/byte_seq_checker.sv
module byte_seq_checker #(
  parameter int PA_W = 8,
  parameter int DA_W = 8
) (
  input logic            clk,
  input logic            rst,
  input seq_pkg::state_t state,
  input seq_pkg::kind_t  kind,
  input logic [7:0]      opnd,
  input logic [PA_W-1:0] prog_addr,
  input logic [DA_W-1:0] mem_addr,
  input logic            mem_addr_sel,
  input logic            mem_we,
  input logic            in_empty,
  input logic            in_pop,
  input logic            out_full,
  input logic            out_push,
  input logic            pc_load,
  input logic            halted
);
  import seq_pkg::*;

  AST_RESET_PC: assert property (@(posedge clk)
    rst |=> (prog_addr == '0 && !halted)); // R1

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    in_empty |-> !in_pop); // R2

  AST_INBOX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && kind == K_IN && in_empty)
      |=> (state == S_DECODE && $stable(prog_addr))); // R3

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    out_full |-> !out_push); // R4

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> (prog_addr == $past(opnd[PA_W-1:0]))); // R5

  AST_SHORT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_addr_sel) |-> (mem_addr < DA_W'(3))); // R9

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(prog_addr))); // R10

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_pop, out_push, mem_we})); // R11
endmodule

bind byte_seq_core byte_seq_checker #(.PA_W(PA_W), .DA_W(DA_W)) u_chk (
  .clk(clk), .rst(rst), .state(state), .kind(kind), .opnd(opnd),
  .prog_addr(prog_addr), .mem_addr(mem_addr), .mem_addr_sel(mem_addr_sel),
  .mem_we(mem_we), .in_empty(in_empty), .in_pop(in_pop),
  .out_full(out_full), .out_push(out_push), .pc_load(pc_load),
  .halted(halted)
);

// File: tb/sim_byte_seq_core.sv
module sim_byte_seq_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] prog_addr, prog_data, mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, mem_addr_sel, in_empty, in_pop, out_full, out_push, halted;
  logic [7:0] in_data, out_data;

  logic [7:0] prog [0:255];
  logic [7:0] dmem [0:255];
  logic [7:0] inq [$];
  logic [7:0] outq [$];
  int checks = 0, errors = 0, stall_in = 0, stall_out = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign prog_data = prog[prog_addr];
  assign mem_rdata = dmem[mem_addr];

  byte_seq_core u0 (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_data(prog_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .mem_addr_sel(mem_addr_sel), .in_empty(in_empty),
    .in_data(in_data), .in_pop(in_pop), .out_full(out_full),
    .out_data(out_data), .out_push(out_push), .halted(halted)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model: phase 0 fetch, 1 decode, 2 operand, 3 execute, 4 stopped
  int m_pc, m_ir, m_op, m_acc, m_ph;
  int n_pc, n_ir, n_op, n_acc, n_ph;
  bit e_pop, e_push, e_we, e_sel;
  int e_maddr;

  initial begin
    for (int i = 0; i < 256; i++) begin prog[i] = 8'h55; dmem[i] = 8'h00; end
    dmem[2] = 8'h9C;
    prog[0]=8'h00; prog[1]=8'h31; prog[2]=8'h10; prog[3]=8'h23; prog[4]=8'h40;
    prog[5]=8'h90; prog[6]=8'h09; prog[7]=8'h10; prog[8]=8'h10; prog[9]=8'h00;
    prog[10]=8'h90; prog[11]=8'h00; prog[12]=8'h33; prog[13]=8'h50; prog[14]=8'h21;
    prog[15]=8'h10; prog[16]=8'h80; prog[17]=8'h14; prog[18]=8'h10; prog[19]=8'h10;
    prog[20]=8'h22; prog[21]=8'h10; prog[22]=8'h55;
    inq.push_back(8'h05);
    in_empty = 1'b0; in_data = 8'h05; out_full = 1'b0;
    m_pc = 0; m_ir = 0; m_op = 0; m_acc = 0; m_ph = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(prog_addr == 8'd0 && !in_pop && !out_push && !mem_we && !halted,
        "R1 reset state", {prog_addr, 3'b0, in_pop, out_push, mem_we, halted}, 0);
    @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < 90; cyc++) begin
      if (cyc == 35) inq.push_back(8'h07);
      in_empty = (inq.size() == 0);
      in_data  = in_empty ? 8'h00 : inq[0];
      out_full = (cyc >= 4 && cyc < 11);
      #1;
      n_pc = m_pc; n_ir = m_ir; n_op = m_op; n_acc = m_acc; n_ph = m_ph;
      e_pop = 0; e_push = 0; e_we = 0; e_sel = 0; e_maddr = 0;
      case (m_ph)
        0: begin n_ir = prog[m_pc]; n_pc = (m_pc + 1) % 256; n_ph = 1; end
        1: begin
          if (m_ir / 16 == 0) begin
            if (!in_empty) begin e_pop = 1; n_acc = in_data; n_ph = 0; end
            else stall_in++;
          end else if (m_ir / 16 == 1) begin
            if (!out_full) begin e_push = 1; n_ph = 0; end
            else stall_out++;
          end else if (m_ir / 16 == 2 || m_ir / 16 == 3)
            n_ph = (m_ir % 4 == 3) ? 2 : 3;
          else if (m_ir / 16 == 8 || m_ir / 16 == 9) n_ph = 2;
          else n_ph = 4;
        end
        2: begin n_op = prog[m_pc]; n_pc = (m_pc + 1) % 256; n_ph = 3; end
        3: begin
          e_sel   = (m_ir % 4 != 3);
          e_maddr = e_sel ? m_ir % 4 : m_op;
          if (m_ir / 16 == 2) n_acc = dmem[e_maddr];
          if (m_ir / 16 == 3) e_we = 1;
          if (m_ir / 16 == 8 || (m_ir / 16 == 9 && m_acc == 0)) n_pc = m_op;
          n_ph = 0;
        end
        default: n_ph = 4;
      endcase
      chk(prog_addr == m_pc, "R1 R5 R6 prog_addr", prog_addr, m_pc);
      chk(in_pop == e_pop, "R2 R3 in_pop", in_pop, e_pop);
      chk(out_push == e_push, "R4 out_push", out_push, e_push);
      chk(mem_we == e_we, "R8 mem_we", mem_we, e_we);
      chk(halted == (m_ph == 4), "R10 halted", halted, m_ph == 4);
      if (e_push) chk(out_data == m_acc, "R4 out_data", out_data, m_acc);
      if (e_we) begin
        chk(mem_addr == e_maddr, "R8 R9 mem_addr", mem_addr, e_maddr);
        chk(mem_wdata == m_acc, "R8 mem_wdata", mem_wdata, m_acc);
      end
      if (m_ph == 3 && (m_ir / 16 == 2 || m_ir / 16 == 3)) begin
        chk(mem_addr_sel == e_sel, "R7 R9 mem_addr_sel", mem_addr_sel, e_sel);
        if (m_ir / 16 == 2)
          chk(mem_addr == e_maddr, "R7 R9 read address", mem_addr, e_maddr);
      end
      chk((in_pop + out_push + mem_we) <= 1, "R11 strobes",
          {in_pop, out_push, mem_we}, 0);
      @(negedge clk);
      if (e_pop) void'(inq.pop_front());
      if (e_push) outq.push_back(m_acc[7:0]);
      if (e_we) dmem[e_maddr] = m_acc[7:0];
      m_pc = n_pc; m_ir = n_ir; m_op = n_op; m_acc = n_acc; m_ph = n_ph;
    end
    #1;
    chk(outq.size() == 3, "R4 R5 R6 output count", outq.size(), 3);
    if (outq.size() == 3) begin
      chk(outq[0] == 8'h05, "R4 first output", outq[0], 8'h05);
      chk(outq[1] == 8'h05, "R9 compact read output", outq[1], 8'h05);
      chk(outq[2] == 8'h9C, "R9 compact addr 2 output", outq[2], 8'h9C);
    end
    chk(dmem[1] == 8'h05, "R9 compact write", dmem[1], 8'h05);
    chk(dmem[8'h50] == 8'h07, "R8 long write", dmem[8'h50], 8'h07);
    chk(inq.size() == 0, "R2 inbox drained", inq.size(), 0);
    chk(stall_in > 0, "R3 inbox stall seen", stall_in, 1);
    chk(stall_out > 0, "R4 outbox stall seen", stall_out, 1);
    chk(halted == 1'b1, "R10 halted at end", halted, 1);
    chk(prog_addr == 8'd23, "R10 pc frozen", prog_addr, 23);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule